// File: doc/BRIEF.md
# PLL Divider Pair Search Engine

This block takes a target pixel frequency, given in hundredths of a megahertz, and finds the feedback and reference divider pair of a frequency synthesizer whose output lands closest to that target. The synthesizer runs from a 14.31818 MHz reference. The block first limits the target to the supported band. It then picks a power-of-two post-divider exponent. After that it tries every divider pair in turn and keeps the pair with the smallest absolute error. The result is a 16-bit program word that carries the two dividers and the exponent. Writing that word into the synthesizer is done elsewhere.

A request starts with a one-cycle `start_i` pulse while the engine is idle. It also starts if the pulse comes in the cycle that reports the previous result. Each candidate is computed with fixed-point arithmetic. Every candidate takes one pass through a multi-bit-per-cycle sequential divider, so a full search lasts tens of thousands of cycles. The state machine has six states:

- `S_IDLE`: waits for a request.
- `S_SCALE`: doubles the working frequency once per cycle and counts the exponent.
- `S_ISSUE`: starts the divider for the current pair.
- `S_DIVIDE`: waits for the divider.
- `S_COMPARE`: scores the candidate and steps the pair.
- `S_FINISH`: presents the result for one cycle.

The transitions are:

- `S_IDLE` or `S_FINISH` goes to `S_SCALE` on a nonzero request.
- `S_IDLE` or `S_FINISH` goes to `S_FINISH` on a zero request.
- `S_IDLE` stays in `S_IDLE` with no request, and `S_FINISH` goes to `S_IDLE` with no request.
- `S_SCALE` stays in `S_SCALE` while the frequency is below the floor, then goes to `S_ISSUE`.
- `S_ISSUE` goes to `S_DIVIDE`.
- `S_DIVIDE` goes to `S_COMPARE` when the divider finishes.
- `S_COMPARE` goes back to `S_ISSUE` for the next pair, or to `S_FINISH` after the last pair.

Top module: `pll_mn_search`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o` is 0 and `prog_word_o` is 0.
- R2: A nonzero target below 8000 gives the same word as 8000. A target above 15938 gives the same word as 15938.
- R3: A zero target skips the search. In the cycle after the start is accepted, `done_o` is 1 and the word is 0x00E0.
- R4: Word layout: N sits in bits 15:8, the exponent k in bits 7:6 and M in bits 5:0. M lies in 2..30 and N lies in 35..247.
- R5: The word is built from the pair that minimises the absolute error E = |floor(938356·(N+8) / (2^k·256·(M+2))) − floor(f·256/100)|, where f is the clamped target. M is scanned in ascending order in the outer loop and N in ascending order in the inner loop. The best pair is replaced only by a strictly smaller E, so on a tie the first pair found is kept.
- R6: k starts at 0. k is incremented and f is doubled while f < 64000. For every nonzero target, bits 7:6 of the word are therefore 11.
- R7: `done_o` is high for exactly one cycle per accepted request and never without one.
- R8: `prog_word_o` changes only in a cycle where `done_o` is high. A start that arrives during a search is ignored.
- R9: A start in the cycle where `done_o` is high is accepted and begins a new request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle or in the result cycle |
| target_i | input | 16 | Target frequency in 0.01 MHz units |
| done_o | output | 1 | One-cycle result strobe |
| prog_word_o | output | 16 | Packed program word |

## Verification
The result strobe of one request and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start_i` in the cycle where `done_o` is seen high. It does this once with a nonzero target, and once with a zero target that must itself report in the very next cycle. It judges the case in two ways. The reference model has to see one strobe per accepted request, each carrying the word the model computed for that request. The word must also not move between strobes. A start given in the middle of a search is checked the same way: it must not add a strobe or change the result.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCALE,
        S_ISSUE,
        S_DIVIDE,
        S_COMPARE,
        S_FINISH
    } search_state_e;

    // N in [15:8], exponent in [7:6], M in [5:0]; fields added, not or-ed
    function automatic logic [15:0] pack_word(input logic [2:0] k,
                                              input logic [7:0] m,
                                              input logic [7:0] n);
        logic [15:0] w;
        w = {n, 8'h00};
        w = w + {7'b0, k, 6'b0};
        w = w + {8'h00, m};
        return w;
    endfunction

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int unsigned DVD_W = 18,
    parameter int unsigned DVS_W = 6,
    parameter int unsigned STEP  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quo_o,
    output logic [DVS_W-1:0] rem_o
);
    localparam int unsigned CYC   = (DVD_W + STEP - 1) / STEP;
    localparam int unsigned PAD_W = CYC * STEP;
    localparam int unsigned CNT_W = $clog2(CYC + 1);

    logic [PAD_W-1:0] quo_q, quo_n;
    logic [DVS_W-1:0] rem_q, rem_n, dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;

    // STEP restoring stages per cycle
    always_comb begin
        logic [DVS_W:0]   r;
        logic [PAD_W-1:0] q;
        r = {1'b0, rem_q};
        q = quo_q;
        for (int i = 0; i < STEP; i++) begin
            r = {r[DVS_W-1:0], q[PAD_W-1]};
            q = {q[PAD_W-2:0], 1'b0};
            if (r >= {1'b0, dvs_q}) begin
                r    = r - {1'b0, dvs_q};
                q[0] = 1'b1;
            end
        end
        rem_n = r[DVS_W-1:0];
        quo_n = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                quo_q  <= PAD_W'(dividend_i);
                rem_q  <= '0;
                dvs_q  <= divisor_i;
                cnt_q  <= CNT_W'(CYC);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                quo_q <= quo_n;
                rem_q <= rem_n;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q[DVD_W-1:0];
    assign rem_o  = rem_q;

    // R5: a finished division leaves a remainder below the divisor
    p_rem_below_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rem_q < dvs_q));

endmodule

// File: rtl/pll_best_track.sv
module pll_best_track #(
    parameter int unsigned ERR_W = 32,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             upd_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic [IDX_W-1:0] m_i,
    input  logic [IDX_W-1:0] n_i,
    output logic [IDX_W-1:0] pick_m_o,
    output logic [IDX_W-1:0] pick_n_o
);
    logic [ERR_W-1:0] best_q;
    logic [IDX_W-1:0] bm_q, bn_q;
    logic             better;

    assign better   = upd_i && (err_i < best_q);
    assign pick_m_o = better ? m_i : bm_q;
    assign pick_n_o = better ? n_i : bn_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            best_q <= '1;
            bm_q   <= '0;
            bn_q   <= '0;
        end else if (better) begin
            best_q <= err_i;
            bm_q   <= m_i;
            bn_q   <= n_i;
        end
    end

    // R5: within a search the kept error never grows
    p_best_nonincr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (best_q <= $past(best_q)));

endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
    import pll_search_pkg::*;
#(
    parameter int unsigned REF_SCALED = 938356,
    parameter int unsigned F_MIN      = 8000,
    parameter int unsigned F_MAX      = 15938,
    parameter int unsigned SCALE_MULT = 8,
    parameter int unsigned M_LO       = 2,
    parameter int unsigned M_HI       = 30,
    parameter int unsigned N_LO       = 35,
    parameter int unsigned N_HI       = 247,
    parameter int unsigned M_OFS      = 2,
    parameter int unsigned N_OFS      = 8,
    parameter int unsigned FRAC_BITS  = 8,
    parameter int unsigned PCT        = 100,
    parameter int unsigned FREQ_IN_W  = 16,
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned ZERO_WORD  = 'h00E0,
    parameter int unsigned K_W        = 3,
    parameter int unsigned DVD_W      = 18,
    parameter int unsigned DVS_W      = 6,
    parameter int unsigned DIV_STEP   = 6,
    parameter int unsigned ERR_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [FREQ_IN_W-1:0] target_i,
    output logic                 done_o,
    output logic [WORD_W-1:0]    prog_word_o
);
    localparam int unsigned IDX_W   = WORD_W / 2;
    localparam int unsigned FREQ_W  = FREQ_IN_W + K_W + 1;
    localparam int unsigned LONG_W  = FREQ_IN_W + FRAC_BITS;
    localparam int unsigned PROD_W  = 32;
    localparam int unsigned F_FLOOR = F_MIN * SCALE_MULT;

    search_state_e state_q, state_d;

    logic [FREQ_W-1:0]    freq_q;
    logic [LONG_W-1:0]    long_q;
    logic [K_W-1:0]       k_q;
    logic [IDX_W-1:0]     m_q, n_q;
    logic [WORD_W-1:0]    prog_q;

    logic                 accept, zero_req, last_cand;
    logic [FREQ_IN_W-1:0] tgt_clamped;
    logic [LONG_W-1:0]    long_c;
    logic [PROD_W-1:0]    prod_c, shifted_c;
    logic [DVD_W-1:0]     dividend_c;
    logic [DVS_W-1:0]     divisor_c;
    logic [ERR_W-1:0]     q_ext, l_ext, err_c;
    logic                 div_done;
    logic [DVD_W-1:0]     div_quo;
    logic [DVS_W-1:0]     div_rem;
    logic [IDX_W-1:0]     pick_m, pick_n;

    // ---------------- request decode ----------------
    assign accept   = start_i && ((state_q == S_IDLE) || (state_q == S_FINISH));
    assign zero_req = (target_i == '0);

    always_comb begin
        if (target_i < FREQ_IN_W'(F_MIN))      tgt_clamped = FREQ_IN_W'(F_MIN);
        else if (target_i > FREQ_IN_W'(F_MAX)) tgt_clamped = FREQ_IN_W'(F_MAX);
        else                                   tgt_clamped = target_i;
    end

    assign long_c = (LONG_W'(tgt_clamped) << FRAC_BITS) / LONG_W'(PCT);

    // ---------------- candidate datapath ----------------
    // power-of-two part of the denominator becomes a shift
    assign prod_c     = PROD_W'(REF_SCALED) * PROD_W'(n_q + IDX_W'(N_OFS));
    assign shifted_c  = prod_c >> (PROD_W'(FRAC_BITS) + PROD_W'(k_q));
    assign dividend_c = DVD_W'(shifted_c);
    assign divisor_c  = DVS_W'(m_q + IDX_W'(M_OFS));

    assign q_ext = ERR_W'(div_quo);
    assign l_ext = ERR_W'(long_q);
    assign err_c = (q_ext > l_ext) ? (q_ext - l_ext) : (l_ext - q_ext);

    assign last_cand = (m_q == IDX_W'(M_HI)) && (n_q == IDX_W'(N_HI));

    pll_seq_div #(
        .DVD_W (DVD_W),
        .DVS_W (DVS_W),
        .STEP  (DIV_STEP)
    ) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (state_q == S_ISSUE),
        .dividend_i (dividend_c),
        .divisor_i  (divisor_c),
        .done_o     (div_done),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    pll_best_track #(
        .ERR_W (ERR_W),
        .IDX_W (IDX_W)
    ) best_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (accept && !zero_req),
        .upd_i    (state_q == S_COMPARE),
        .err_i    (err_c),
        .m_i      (m_q),
        .n_i      (n_q),
        .pick_m_o (pick_m),
        .pick_n_o (pick_n)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_FINISH: begin
                if (accept) state_d = zero_req ? S_FINISH : S_SCALE;
                else        state_d = S_IDLE;
            end
            S_SCALE:   state_d = (freq_q < FREQ_W'(F_FLOOR)) ? S_SCALE : S_ISSUE;
            S_ISSUE:   state_d = S_DIVIDE;
            S_DIVIDE:  state_d = div_done ? S_COMPARE : S_DIVIDE;
            S_COMPARE: state_d = last_cand ? S_FINISH : S_ISSUE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- working registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            long_q <= '0;
            k_q    <= '0;
            m_q    <= '0;
            n_q    <= '0;
            prog_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE, S_FINISH: begin
                    if (accept) begin
                        if (zero_req) begin
                            prog_q <= WORD_W'(ZERO_WORD);
                        end else begin
                            freq_q <= FREQ_W'(tgt_clamped);
                            long_q <= long_c;
                            k_q    <= '0;
                            m_q    <= IDX_W'(M_LO);
                            n_q    <= IDX_W'(N_LO);
                        end
                    end
                end
                S_SCALE: begin
                    if (freq_q < FREQ_W'(F_FLOOR)) begin
                        freq_q <= freq_q << 1;
                        k_q    <= k_q + K_W'(1);
                    end
                end
                S_COMPARE: begin
                    if (last_cand) begin
                        prog_q <= pack_word(k_q, pick_m, pick_n);
                    end else if (n_q == IDX_W'(N_HI)) begin
                        n_q <= IDX_W'(N_LO);
                        m_q <= m_q + IDX_W'(1);
                    end else begin
                        n_q <= n_q + IDX_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        done_o      = (state_q == S_FINISH);
        prog_word_o = prog_q;
    end

    // ---------------- assertions ----------------
    p_zero_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zero_req) |=> (done_o && (prog_word_o == WORD_W'(ZERO_WORD))));

    p_index_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMPARE) |->
            ((m_q >= IDX_W'(M_LO)) && (m_q <= IDX_W'(M_HI)) &&
             (n_q >= IDX_W'(N_LO)) && (n_q <= IDX_W'(N_HI))));

    p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> ((ERR_W'(div_quo) * ERR_W'(divisor_c) + ERR_W'(div_rem))
                      == ERR_W'(dividend_c)));

    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    p_word_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(prog_word_o));

endmodule

// File: tb/pll_mn_search_tb_top.sv
module pll_mn_search_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] target;
    logic        done;
    logic [15:0] word;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int exp_q[$];
    bit m_idle = 1'b1;
    logic [15:0] last_word = 16'h0000;

    always #10 clk = ~clk;

    pll_mn_search dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .target_i    (target),
        .done_o      (done),
        .prog_word_o (word)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // behavioural model of the requirements
    function automatic int ref_word(input int t);
        longint f, lng, a, b, fo, d, best;
        int k, sm, sn;
        if (t == 0) return 'hE0;
        f = (t < 8000) ? 8000 : ((t > 15938) ? 15938 : t);
        lng = f * 256 / 100;
        k = 0;
        while (f < 64000) begin
            f = f * 2;
            k++;
        end
        best = 64'hFFFF_FFFF;
        sm = 0;
        sn = 0;
        for (int m = 2; m <= 30; m++) begin
            for (int n = 35; n <= 247; n++) begin
                a  = longint'(938356) * (n + 8);
                b  = (longint'(1) << k) * 256 * (m + 2);
                fo = a / b;
                d  = (lng > fo) ? (lng - fo) : (fo - lng);
                if (d < best) begin
                    best = d;
                    sm = m;
                    sn = n;
                end
            end
        end
        return ((k << 6) + sm + (sn << 8)) & 'hFFFF;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        bit acc;
        if (rst_n === 1'b1) begin
            acc = start && (m_idle || done);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 strobe without request", int'(done), 0);
                end else begin
                    check(word == exp_q[0][15:0], "R5 result word", int'(word), exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end else begin
                check(word == last_word, "R8 word stable", int'(word), int'(last_word));
            end
            last_word = word;
            if (acc) begin
                exp_q.push_back(ref_word(int'(target)));
                m_idle = 1'b0;
            end else if (done) begin
                m_idle = 1'b1;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=195000", cyc);
            finish_run();
        end
    end

    task automatic issue(input int t);
        @(posedge clk); #2;
        start  = 1'b1;
        target = 16'(t);
        @(posedge clk); #2;
        start  = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic start_on_done(input int t);
        do begin
            @(posedge clk); #2;
        end while (!done);
        start  = 1'b1;
        target = 16'(t);
        @(posedge clk); #2;
        start  = 1'b0;
    endtask

    initial begin
        rst_n  = 1'b0;
        start  = 1'b0;
        target = 16'h0000;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(word == 16'h0000, "R1 reset word", int'(word), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        #5;
        check(done == 1'b0, "R1 first cycle done", int'(done), 0);

        // R3: zero target reports in the next cycle
        issue(0);
        check(done == 1'b1, "R3 zero target latency", int'(done), 1);
        check(word == 16'h00E0, "R3 zero target word", int'(word), 'hE0);
        wait_idle();

        // R2 low clamp, R8 start during search ignored
        issue(5000);
        repeat (200) @(posedge clk);
        #2;
        start  = 1'b1;
        target = 16'd9000;
        @(posedge clk); #2;
        start  = 1'b0;
        wait_idle();
        check(word == 16'(ref_word(8000)), "R2 low clamp", int'(word), ref_word(8000));

        // R2 high clamp, R4 field ranges, R6 exponent
        issue(20000);
        wait_idle();
        check(word == 16'(ref_word(15938)), "R2 high clamp", int'(word), ref_word(15938));
        check(word[7:6] == 2'b11, "R6 exponent field", int'(word[7:6]), 3);
        check((word[5:0] >= 6'd2) && (word[5:0] <= 6'd30), "R4 M field", int'(word[5:0]), 2);
        check((word[15:8] >= 8'd35) && (word[15:8] <= 8'd247), "R4 N field", int'(word[15:8]), 35);

        // R9: back-to-back requests on the strobe cycle
        issue(12000);
        start_on_done(10000);
        check(done == 1'b0, "R9 new search started", int'(done), 0);
        start_on_done(0);
        check(done == 1'b1, "R9 zero after strobe", int'(done), 1);
        check(word == 16'h00E0, "R9 zero word after strobe", int'(word), 'hE0);
        check(word[7:6] == 2'b11 || word == 16'h00E0, "R6 exponent", int'(word), 'hE0);
        wait_idle();
        repeat (3) @(posedge clk);
        #2;
        check(exp_q.size() == 0, "R7 all requests answered", exp_q.size(), 0);
        check(done == 1'b0, "R7 strobe ended", int'(done), 0);

        finish_run();
    end

endmodule